// File: doc/BRIEF.md
# Processor Bus Cycle Controller

This block runs the external bus transactions of a small 8-bit processor core. The core asks for one transaction at a time over a simple request port. A request carries a two-bit kind, a 16-bit address and, for stores, a write byte. The controller steps through an address phase, a strobe phase, optional wait phases and a closing phase. It then returns a one-cycle completion pulse, which carries the captured byte on reads.

Slow devices stretch a cycle by holding the ready input low. An external master, such as a DMA engine, can take the bus by raising hold. The controller finishes any cycle already in flight, then stops driving every address, data and control line and raises an acknowledge. The data bus is split into an output value, an input value and an output enable, so the tri-state buffer can sit at the pad. The address and control groups each have their own enable as well.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: A synchronous reset, even in the middle of a transaction, leads to this state on the following cycle: address 0000h, address and control enables high, both strobes high (inactive), data enable low, hold acknowledge low and done low.
- R2: The kind code sets the space and direction of a transaction. Bit 1 set means I/O space, and `bus_io_m` is high from T1 to the end of the cycle. Bit 0 set means a write. Codes: 00 memory read, 01 memory write, 10 I/O read, 11 I/O write.
- R3: A read places the address in T1 with both strobes high. It then holds `bus_rd_n` low from T2 through T3. `bus_data_i` is captured at the clock edge that ends T3 and appears on `rdata`, with `done` high for exactly the next cycle.
- R4: A write drives `bus_data_o` with `bus_data_oe` high from T1 through T3. It holds `bus_wr_n` low from T2 through T3, and leaves `rdata` unchanged when `done` pulses.
- R5: `bus_rd_n` and `bus_wr_n` are never low in the same cycle.
- R6: Each clock edge that ends T2 or a wait state with `ready_in` low adds one wait state. During wait states the address and both strobes stay unchanged.
- R7: `ready_in` is looked at only at the end of T2 and of wait states. A low level during T1 or T3 does not lengthen the cycle.
- R8: With `hold_req` high while idle, the next cycle shows `hold_ack` high, with the address, data and control enables low and `req_ready` low.
- R9: A hold request raised during a transaction does not cut it short. `hold_ack` rises in the same cycle as that transaction's `done` pulse.
- R10: When `hold_req` falls, the next cycle shows `hold_ack` low, the address and control enables high, and the last transaction's address on `bus_addr`.
- R11: A request is taken only when `req_ready` is high, which means idle with `hold_req` low. A request presented while busy or while hold is pending or granted starts no cycle and leaves the address unchanged.
- R12: `req_ready` is high in the cycle where `done` pulses, unless hold is requested, so a new request can start T1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transaction request from the core |
| req_kind | input | 2 | Kind code: bit 1 I/O space, bit 0 write |
| req_addr | input | 16 | Transaction address |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | Controller can take a request this cycle |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte captured by the last read |
| bus_addr | output | 16 | Address bus value |
| bus_addr_oe | output | 1 | Address bus output enable |
| bus_data_o | output | 8 | Data bus value driven on writes |
| bus_data_i | input | 8 | Data bus value seen from the pads |
| bus_data_oe | output | 1 | Data bus output enable |
| bus_io_m | output | 1 | High for I/O space, low for memory |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_ctl_oe | output | 1 | Output enable for strobes and space select |
| ready_in | input | 1 | Device ready; low inserts wait states |
| hold_req | input | 1 | External master asks for the bus |
| hold_ack | output | 1 | Bus released to the external master |

## Verification
The properties assume that `req_valid`, `ready_in` and `hold_req` are synchronous to `clk`, with no metastable values, and that reset is held for at least one edge before any request. They also assume `bus_data_i` is only read, never checked for being driven, so any value is legal. The stimulus changes every input only on the falling clock edge. It starts with reset high, and it raises hold or request pokes only inside the phases whose outcome the requirements define.

// File: rtl/bus_cycle_pkg.sv
package bus_cycle_pkg;

  // Bus cycle phases; T1..T3 with optional wait phases between T2 and T3
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_TW   = 3'd3,
    ST_T3   = 3'd4,
    ST_HOLD = 3'd5
  } state_t;

  localparam int KIND_W = 2;

  // Kind code bit positions
  localparam int KIND_WR_BIT = 0;
  localparam int KIND_IO_BIT = 1;

  function automatic logic strobe_phase(input state_t s);
    return (s == ST_T2) || (s == ST_TW) || (s == ST_T3);
  endfunction

  function automatic logic cycle_phase(input state_t s);
    return (s == ST_T1) || strobe_phase(s);
  endfunction

endpackage

// File: rtl/bus_cycle_fsm.sv
module bus_cycle_fsm
  import bus_cycle_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   req_valid,
  input  logic   ready_in,
  input  logic   hold_req,
  output state_t st_q,
  output state_t st_d,
  output logic   accept,
  output logic   req_ready
);

  always_comb begin
    req_ready = (st_q == ST_IDLE) && !hold_req;
    accept    = req_valid && req_ready;
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (hold_req)       st_d = ST_HOLD;
        else if (req_valid) st_d = ST_T1;
      end
      ST_T1:   st_d = ST_T2;
      ST_T2:   st_d = ready_in ? ST_T3 : ST_TW;
      ST_TW:   st_d = ready_in ? ST_T3 : ST_TW;
      ST_T3:   st_d = hold_req ? ST_HOLD : ST_IDLE;
      ST_HOLD: st_d = hold_req ? ST_HOLD : ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end

endmodule

// File: rtl/bus_req_regs.sv
module bus_req_regs
  import bus_cycle_pkg::*;
#(
  parameter int              ADDR_W     = 16,
  parameter int              DATA_W     = 8,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [KIND_W-1:0] req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  state_t            st_q,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic [ADDR_W-1:0] addr_q,
  output logic [KIND_W-1:0] kind_q,
  output logic [KIND_W-1:0] kind_nx,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              done_q
);

  assign kind_nx = accept ? req_kind : kind_q;

  // Request latch: held for the whole cycle and kept afterwards
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= RESET_ADDR;
      kind_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      kind_q  <= req_kind;
      wdata_q <= req_wdata;
    end
  end

  // Read data is taken at the edge that closes T3
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= (st_q == ST_T3);
      if ((st_q == ST_T3) && !kind_q[KIND_WR_BIT])
        rdata_q <= bus_data_i;
    end
  end

endmodule

// File: rtl/bus_pin_drive.sv
module bus_pin_drive
  import bus_cycle_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  state_t            st_d,
  input  logic [KIND_W-1:0] kind_nx,
  output logic              rd_n,
  output logic              wr_n,
  output logic              io_m,
  output logic              addr_oe,
  output logic              ctl_oe,
  output logic              data_oe,
  output logic              hold_ack
);

  logic wr_nx;
  logic strobe_nx;
  logic released_nx;

  always_comb begin
    wr_nx       = kind_nx[KIND_WR_BIT];
    strobe_nx   = strobe_phase(st_d);
    released_nx = (st_d == ST_HOLD);
  end

  // Every pin is a flop fed from the next state
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_n     <= 1'b1;
      wr_n     <= 1'b1;
      io_m     <= 1'b0;
      addr_oe  <= 1'b1;
      ctl_oe   <= 1'b1;
      data_oe  <= 1'b0;
      hold_ack <= 1'b0;
    end else begin
      rd_n     <= !(strobe_nx && !wr_nx);
      wr_n     <= !(strobe_nx && wr_nx);
      io_m     <= kind_nx[KIND_IO_BIT];
      addr_oe  <= !released_nx;
      ctl_oe   <= !released_nx;
      data_oe  <= cycle_phase(st_d) && wr_nx;
      hold_ack <= released_nx;
    end
  end

endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
  import bus_cycle_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter int                DATA_W     = 8,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_addr_oe,
  output logic [DATA_W-1:0] bus_data_o,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic              bus_data_oe,
  output logic              bus_io_m,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic              bus_ctl_oe,
  input  logic              ready_in,
  input  logic              hold_req,
  output logic              hold_ack
);

  state_t            st_q;
  state_t            st_d;
  logic              accept;
  logic [KIND_W-1:0] kind_q;
  logic [KIND_W-1:0] kind_nx;

  bus_cycle_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .ready_in  (ready_in),
    .hold_req  (hold_req),
    .st_q      (st_q),
    .st_d      (st_d),
    .accept    (accept),
    .req_ready (req_ready)
  );

  bus_req_regs #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .RESET_ADDR (RESET_ADDR)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .req_kind   (req_kind),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .st_q       (st_q),
    .bus_data_i (bus_data_i),
    .addr_q     (bus_addr),
    .kind_q     (kind_q),
    .kind_nx    (kind_nx),
    .wdata_q    (bus_data_o),
    .rdata_q    (rdata),
    .done_q     (done)
  );

  bus_pin_drive u_pins (
    .clk      (clk),
    .rst      (rst),
    .st_d     (st_d),
    .kind_nx  (kind_nx),
    .rd_n     (bus_rd_n),
    .wr_n     (bus_wr_n),
    .io_m     (bus_io_m),
    .addr_oe  (bus_addr_oe),
    .ctl_oe   (bus_ctl_oe),
    .data_oe  (bus_data_oe),
    .hold_ack (hold_ack)
  );

endmodule

// File: rtl/bus_cycle_ctrl_chk.sv
module bus_cycle_ctrl_chk
  import bus_cycle_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input state_t            st_q,
  input logic              bus_rd_n,
  input logic              bus_wr_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_addr_oe,
  input logic              bus_data_oe,
  input logic              bus_ctl_oe,
  input logic              hold_ack,
  input logic              done,
  input logic              ready_in,
  input logic              req_valid,
  input logic              req_ready
);

  // R5: strobes are exclusive
  a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(!bus_rd_n && !bus_wr_n));

  // R3: read strobe falls only after the address has been set up for a cycle
  a_r3_addr_before_rd: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_rd_n) |-> ($stable(bus_addr) && bus_addr_oe));

  // R6: ready low in T2 or a wait state keeps address and strobes steady
  a_r6_wait_steady: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_T2 || st_q == ST_TW) && !ready_in)
      |=> (st_q == ST_TW && $stable(bus_addr) && $stable(bus_rd_n) && $stable(bus_wr_n)));

  // R8: granted bus means every driver is off
  a_r8_release_lines: assert property (@(posedge clk) disable iff (rst)
    hold_ack |-> (!bus_addr_oe && !bus_data_oe && !bus_ctl_oe));

  // R9: hold is entered only from idle or from the closing phase
  a_r9_hold_between: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_HOLD && $past(st_q) != ST_HOLD)
      |-> ($past(st_q) == ST_IDLE || $past(st_q) == ST_T3));

  // R11: no request is taken while the bus is granted away
  a_r11_no_accept_in_hold: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |-> !hold_ack);

  // R3: done follows the closing phase and lasts one cycle
  a_r3_done_after_t3: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(st_q) == ST_T3));

  a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

bind bus_cycle_ctrl bus_cycle_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/bus_cycle_ctrl_test.sv
`timescale 1ns/1ps
module bus_cycle_ctrl_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = '0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready;
  logic        done;
  logic [7:0]  rdata;
  logic [15:0] bus_addr;
  logic        bus_addr_oe;
  logic [7:0]  bus_data_o;
  logic [7:0]  bus_data_i = '0;
  logic        bus_data_oe;
  logic        bus_io_m;
  logic        bus_rd_n;
  logic        bus_wr_n;
  logic        bus_ctl_oe;
  logic        ready_in = 1'b1;
  logic        hold_req = 1'b0;
  logic        hold_ack;

  int total = 0;
  int fails = 0;
  int cycles = 0;
  logic [7:0] exp_rdata = 8'h00;

  always #2 clk = ~clk;

  bus_cycle_ctrl uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .done(done), .rdata(rdata), .bus_addr(bus_addr), .bus_addr_oe(bus_addr_oe),
    .bus_data_o(bus_data_o), .bus_data_i(bus_data_i), .bus_data_oe(bus_data_oe),
    .bus_io_m(bus_io_m), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_ctl_oe(bus_ctl_oe), .ready_in(ready_in), .hold_req(hold_req),
    .hold_ack(hold_ack)
  );

  // kind, addr, wdata, device response, wait states
  localparam logic [37:0] VEC [0:5] = '{
    {2'b00, 16'h0000, 8'h00, 8'h5A, 4'd0},
    {2'b01, 16'hFFFF, 8'hC3, 8'h00, 4'd0},
    {2'b10, 16'h00F0, 8'h00, 8'hA5, 4'd2},
    {2'b11, 16'h0042, 8'h7E, 8'h00, 4'd3},
    {2'b00, 16'h8001, 8'h00, 8'hFF, 4'd1},
    {2'b01, 16'h1234, 8'h11, 8'h00, 4'd5}
  };

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 50000);
      finish_run();
    end
  end

  task automatic check_reset_state(input string tag);
    chk(tag, "bus_addr", bus_addr, 16'h0000);
    chk(tag, "addr_oe", bus_addr_oe, 1);
    chk(tag, "ctl_oe", bus_ctl_oe, 1);
    chk(tag, "rd_n", bus_rd_n, 1);
    chk(tag, "wr_n", bus_wr_n, 1);
    chk(tag, "data_oe", bus_data_oe, 0);
    chk(tag, "hold_ack", hold_ack, 0);
    chk(tag, "done", done, 0);
  endtask

  task automatic run_txn(input logic [1:0] k, input logic [15:0] a,
                         input logic [7:0] wd, input logic [7:0] rsp,
                         input int waits, input bit hold_mid, input bit poke);
    bit wr;
    wr = k[0];
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd;
    ready_in = 1'b1; bus_data_i = ~rsp;
    @(negedge clk);
    // T1
    req_valid = 1'b0;
    chk("R3", "T1 address", bus_addr, a);
    chk("R2", "T1 io_m", bus_io_m, k[1]);
    chk("R3", "T1 rd_n high", bus_rd_n, 1);
    chk("R4", "T1 wr_n high", bus_wr_n, 1);
    chk("R4", "T1 data_oe", bus_data_oe, wr);
    if (wr) chk("R4", "T1 data value", bus_data_o, wd);
    if (hold_mid) hold_req = 1'b1;
    ready_in = (waits == 0);
    @(negedge clk);
    // T2
    chk("R3", "T2 rd_n", bus_rd_n, wr);
    chk("R4", "T2 wr_n", bus_wr_n, !wr);
    chk("R5", "T2 strobes exclusive", bus_rd_n | bus_wr_n, 1);
    chk("R9", "T2 hold not granted", hold_ack, 0);
    if (poke) begin
      req_valid = 1'b1; req_addr = ~a;
    end
    for (int i = 1; i <= waits; i++) begin
      @(negedge clk);
      chk("R6", "wait address", bus_addr, a);
      chk("R6", "wait rd_n", bus_rd_n, wr);
      chk("R6", "wait wr_n", bus_wr_n, !wr);
      chk("R6", "wait done low", done, 0);
      ready_in = (i == waits);
    end
    @(negedge clk);
    // T3
    chk("R6", "T3 address", bus_addr, a);
    chk("R3", "T3 rd_n", bus_rd_n, wr);
    chk("R2", "T3 io_m", bus_io_m, k[1]);
    chk("R3", "T3 done low", done, 0);
    ready_in = 1'b0;
    req_valid = 1'b0;
    bus_data_i = rsp;
    if (!wr) exp_rdata = rsp;
    @(negedge clk);
    // closing cycle: done pulse
    chk("R7", "done after T3 despite ready low", done, 1);
    chk(wr ? "R4" : "R3", "rdata", rdata, exp_rdata);
    chk("R3", "post rd_n", bus_rd_n, 1);
    chk("R4", "post wr_n", bus_wr_n, 1);
    chk("R4", "post data_oe", bus_data_oe, 0);
    chk("R9", "hold_ack with done", hold_ack, hold_mid);
    chk("R9", "addr_oe with done", bus_addr_oe, !hold_mid);
    if (!hold_mid) chk("R12", "req_ready in done cycle", req_ready, 1);
    ready_in = 1'b1;
    @(negedge clk);
    chk("R3", "done single cycle", done, 0);
    if (poke) begin
      chk("R11", "busy poke ignored addr", bus_addr, a);
      chk("R11", "busy poke no strobe", bus_rd_n & bus_wr_n, 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_reset_state("R1");
    chk("R1", "req_ready", req_ready, 1);

    for (int i = 0; i < 6; i++)
      run_txn(VEC[i][37:36], VEC[i][35:20], VEC[i][19:12], VEC[i][11:4],
              int'(VEC[i][3:0]), 1'b0, 1'b0);

    // Hold while idle
    hold_req = 1'b1;
    @(negedge clk);
    chk("R8", "hold_ack", hold_ack, 1);
    chk("R8", "addr_oe off", bus_addr_oe, 0);
    chk("R8", "ctl_oe off", bus_ctl_oe, 0);
    chk("R8", "data_oe off", bus_data_oe, 0);
    chk("R8", "req_ready low", req_ready, 0);
    req_valid = 1'b1; req_kind = 2'b00; req_addr = 16'hBEEF;
    repeat (2) @(negedge clk);
    chk("R11", "request ignored under hold", hold_ack, 1);
    chk("R11", "no read strobe under hold", bus_rd_n, 1);
    req_valid = 1'b0;
    hold_req = 1'b0;
    @(negedge clk);
    chk("R10", "hold_ack dropped", hold_ack, 0);
    chk("R10", "addr_oe restored", bus_addr_oe, 1);
    chk("R10", "ctl_oe restored", bus_ctl_oe, 1);
    chk("R10", "last address kept", bus_addr, 16'h1234);
    @(negedge clk);
    chk("R11", "no cycle started", bus_addr, 16'h1234);

    // Hold raised in the middle of a transaction
    run_txn(2'b10, 16'h0300, 8'h00, 8'h3C, 1, 1'b1, 1'b0);
    hold_req = 1'b0;
    @(negedge clk);
    chk("R10", "release after mid hold", hold_ack, 0);
    chk("R10", "address after mid hold", bus_addr, 16'h0300);

    // Request while busy is ignored
    run_txn(2'b01, 16'h0777, 8'h99, 8'h00, 2, 1'b0, 1'b1);

    // Reset during a transaction
    req_valid = 1'b1; req_kind = 2'b00; req_addr = 16'h4444;
    @(negedge clk);
    req_valid = 1'b0;
    ready_in = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    ready_in = 1'b1;
    check_reset_state("R1");

    finish_run();
  end

endmodule